// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the host-side sequencer for a 16-bit successive-approximation converter that has a serial output and is read with a data clock that the host supplies in bursts. On a start request the block drives the read/convert line low. This launches conversion n. It gives one arming clock pulse while that line is low, so that the converter will emit a sync marker. The block then waits for the converter's busy line to go low. It then clocks out the result of conversion n-1 during the conversion that is running. Chip select is assumed to be tied low.

The burst has 18 pulses. The falling edge of pulse 1 samples the sync marker. The falling edges of pulses 2 to 17 capture the word, most significant bit first. Pulse 18 closes the burst. The word is then presented with a one-cycle strobe. The strobe also carries a sync error flag, a stale flag for the first read after reset or after a lost conversion, and a timeout flag for the case where busy never fell. The data clock is built from the system clock. Its half period, the gap between read/convert rising and the first burst edge, the read/convert low width and the busy timeout are all parameters counted in system-clock cycles.

The controller is a five-state machine. From `ST_IDLE`, a start request takes it to `ST_RC_LOW` (the *launch* transition). In `ST_RC_LOW` the read/convert line is low and the arming pulse is issued. When the arming pulse is done and the low width has elapsed, it moves to `ST_WAIT_BUSY` (*release*). In `ST_WAIT_BUSY`, busy low together with an elapsed setup gap moves it to `ST_BURST` (*go*). If busy stays high until the timeout, it moves straight to `ST_DONE` instead (*timeout*). In `ST_BURST`, the fall of pulse 18 moves it to `ST_DONE` (*finish*). `ST_DONE` always returns to `ST_IDLE` (*report*).

Top module: `serial_adc_reader`

## Requirements
- R1: While reset is held and right after it is released, `rc_n` is 1, `sclk` is 0, `active` is 0 and `result_valid` is 0.
- R2: A start request in idle drives `rc_n` low for max(RC_LOW_CYC, 2*SCLK_HALF+1) cycles. Exactly one `sclk` pulse (the arming pulse) rises while `rc_n` is low. `rc_n` falls only in the cycle after `start` was seen high.
- R3: After `rc_n` rises, `sclk` stays low until `busy_n` is low. The first burst rising edge comes at least SETUP_CYC cycles after `rc_n` rose.
- R4: A complete read gives exactly 19 rising edges on `sclk`: the arming pulse plus 18 burst pulses. Each level lasts SCLK_HALF cycles. `sclk` idles low whenever the clock generator is stopped.
- R5: `sync_in` is sampled at the falling edge of burst pulse 1. If it is 0 there, `sync_err` is 1 with the strobe, and otherwise it is 0.
- R6: `sdata_in` is sampled at the falling edges of burst pulses 2 to 17. The first sampled bit lands in `result[15]` and the last in `result[0]`.
- R7: `result_valid` is high for exactly one cycle per read. `result`, `sync_err`, `stale` and `timeout_err` are valid in that cycle.
- R8: `stale` is 1 on the first result after reset and on the first result after a timeout. It is 0 on every other result.
- R9: A start request while `active` is 1 is ignored: no extra `rc_n` fall, no extra pulses, no extra strobe.
- R10: If `busy_n` is still high BUSY_TMO cycles after `rc_n` rose, the block strobes `result_valid` with `timeout_err`=1, `result`=0 and `sync_err`=0, and gives no burst pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request one convert-and-read cycle |
| busy_n | input | 1 | Converter busy, low while converting |
| sync_in | input | 1 | Sync marker from converter |
| sdata_in | input | 1 | Serial data from converter |
| rc_n | output | 1 | Read/convert line, low starts a conversion |
| sclk | output | 1 | Data clock to converter, idles low |
| active | output | 1 | High while a cycle is in progress |
| result | output | 16 | Word from the previous conversion |
| result_valid | output | 1 | One-cycle strobe for the result and flags |
| sync_err | output | 1 | Sync marker was absent on pulse 1 |
| stale | output | 1 | No earlier conversion backs this word |
| timeout_err | output | 1 | Busy never fell |

## Verification
The bench builds the block with SCLK_HALF=2, SETUP_CYC=4, RC_LOW_CYC=6 and BUSY_TMO=40. With RC_LOW_CYC longer than the five-cycle arming pulse, the measured low width checks the parameter and not the pulse length. The four-cycle setup gap is long enough to measure against the first burst edge. The short timeout lets a read with a silent busy line finish in a few dozen cycles. A whole read then fits well inside the 200-cycle busy window of the converter model. This makes back-to-back reads, a missing sync marker and a start request in the middle of a burst all cheap to run.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_RC_LOW    = 3'd1,
        ST_WAIT_BUSY = 3'd2,
        ST_BURST     = 3'd3,
        ST_DONE      = 3'd4
    } rd_state_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
    parameter int HALF = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic fall_evt
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] WRAP = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (!run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (cnt == WRAP) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // high in the cycle whose closing edge drives sclk low
    assign fall_evt = run && sclk && (cnt == WRAP);

    AST_GEN_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sclk); // R4

endmodule

// File: rtl/adc_bit_capture.sv
module adc_bit_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        word <= '0;
        else if (clear)    word <= '0;
        else if (shift_en) word <= {word[W-2:0], bit_in};
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (word == '0)); // R6

endmodule

// File: rtl/adc_wait_timer.sv
module adc_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              count <= '0;
        else if (clear)          count <= '0;
        else if (count != TOP)   count <= count + 1'b1;
    end

endmodule

// File: rtl/serial_adc_reader.sv
module serial_adc_reader
    import adc_rd_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int SCLK_HALF  = 5,
    parameter int SETUP_CYC  = 2,
    parameter int RC_LOW_CYC = 11,
    parameter int BUSY_TMO   = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              busy_n,
    input  logic              sync_in,
    input  logic              sdata_in,
    output logic              rc_n,
    output logic              sclk,
    output logic              active,
    output logic [DATA_W-1:0] result,
    output logic              result_valid,
    output logic              sync_err,
    output logic              stale,
    output logic              timeout_err
);
    localparam int TMAX       = max3(RC_LOW_CYC, SETUP_CYC, BUSY_TMO);
    localparam int TW         = $clog2(TMAX + 1) + 1;
    localparam int LAST_PULSE = DATA_W + 2;
    localparam int PW         = $clog2(LAST_PULSE + 1);
    localparam logic [TW-1:0] RC_END  = TW'(RC_LOW_CYC - 1);
    localparam logic [TW-1:0] GAP_END = TW'(SETUP_CYC - 1);
    localparam logic [TW-1:0] TMO_END = TW'(BUSY_TMO - 1);
    localparam logic [PW-1:0] P_SYNC  = PW'(1);
    localparam logic [PW-1:0] P_MSB   = PW'(2);
    localparam logic [PW-1:0] P_LSB   = PW'(DATA_W + 1);
    localparam logic [PW-1:0] P_LAST  = PW'(LAST_PULSE);

    rd_state_t         state_q, state_d;
    logic [TW-1:0]     tcnt;
    logic [PW-1:0]     pcnt;
    logic              gen_run, fall_evt;
    logic              p0_done, sync_ok, tmo_q, have_prev;
    logic              shift_en, cap_clear, tmr_clear, tmo_hit;
    logic [DATA_W-1:0] word;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        tmo_hit = 1'b0;
        unique case (state_q)
            ST_IDLE:      if (start) state_d = ST_RC_LOW;
            ST_RC_LOW:    if (p0_done && tcnt >= RC_END) state_d = ST_WAIT_BUSY;
            ST_WAIT_BUSY: begin
                if (!busy_n && tcnt >= GAP_END) begin
                    state_d = ST_BURST;
                end else if (busy_n && tcnt >= TMO_END) begin
                    state_d = ST_DONE;
                    tmo_hit = 1'b1;
                end
            end
            ST_BURST:     if (fall_evt && pcnt == P_LAST) state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // ---------------- pin controls ----------------
    assign rc_n      = (state_q != ST_RC_LOW);
    assign active    = (state_q != ST_IDLE);
    assign gen_run   = (state_q == ST_BURST) || (state_q == ST_RC_LOW && !p0_done);
    assign tmr_clear = (state_q != state_d) || (state_q == ST_IDLE);
    assign cap_clear = (state_q == ST_IDLE);
    assign shift_en  = (state_q == ST_BURST) && fall_evt && (pcnt >= P_MSB) && (pcnt <= P_LSB);

    // ---------------- cycle bookkeeping ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt    <= P_SYNC;
            p0_done <= 1'b0;
            sync_ok <= 1'b0;
            tmo_q   <= 1'b0;
        end else begin
            if (state_q != ST_BURST)  pcnt <= P_SYNC;
            else if (fall_evt)        pcnt <= pcnt + 1'b1;

            if (state_q == ST_IDLE)                  p0_done <= 1'b0;
            else if (state_q == ST_RC_LOW && fall_evt) p0_done <= 1'b1;

            if (state_q == ST_IDLE)                                  sync_ok <= 1'b0;
            else if (state_q == ST_BURST && fall_evt && pcnt == P_SYNC) sync_ok <= sync_in;

            if (state_q == ST_IDLE) tmo_q <= 1'b0;
            else if (tmo_hit)       tmo_q <= 1'b1;
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result       <= '0;
            result_valid <= 1'b0;
            sync_err     <= 1'b0;
            stale        <= 1'b0;
            timeout_err  <= 1'b0;
            have_prev    <= 1'b0;
        end else begin
            result_valid <= (state_q == ST_DONE);
            if (state_q == ST_DONE) begin
                result      <= tmo_q ? '0 : word;
                sync_err    <= !tmo_q && !sync_ok;
                stale       <= tmo_q || !have_prev;
                timeout_err <= tmo_q;
                have_prev   <= !tmo_q;
            end
        end
    end

    // ---------------- sub-blocks ----------------
    adc_sclk_gen #(.HALF(SCLK_HALF)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (gen_run),
        .sclk     (sclk),
        .fall_evt (fall_evt)
    );

    adc_bit_capture #(.W(DATA_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cap_clear),
        .shift_en (shift_en),
        .bit_in   (sdata_in),
        .word     (word)
    );

    adc_wait_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_clear),
        .count (tcnt)
    );

    // ---------------- assertions ----------------
    AST_RC_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rc_n) |-> $past(start)); // R2

    AST_NO_CLK_BEFORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_BUSY) |-> !sclk); // R3

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (active && rc_n && start) |=> rc_n); // R9

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid); // R7

    AST_TMO_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && timeout_err) |-> (result == '0 && !sync_err)); // R10

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !sclk); // R4

endmodule

// File: tb/serial_adc_reader_bench.sv
module serial_adc_reader_bench;
    localparam int HALF = 2, SETUP = 4, RCW = 6, TMO = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy_n = 1'b1;
    logic sync_in = 1'b0;
    logic sdata_in = 1'b0;
    logic rc_n, sclk, active, result_valid, sync_err, stale, timeout_err;
    logic [15:0] result;

    always #2 clk = ~clk; // 250 MHz

    serial_adc_reader #(.DATA_W(16), .SCLK_HALF(HALF), .SETUP_CYC(SETUP),
                        .RC_LOW_CYC(RCW), .BUSY_TMO(TMO)) u_serial_adc_reader (
        .clk(clk), .rst_n(rst_n), .start(start), .busy_n(busy_n),
        .sync_in(sync_in), .sdata_in(sdata_in), .rc_n(rc_n), .sclk(sclk),
        .active(active), .result(result), .result_valid(result_valid),
        .sync_err(sync_err), .stale(stale), .timeout_err(timeout_err));

    int total = 0, bad = 0;
    int cyc = 0, rises = 0, convs = 0, valids = 0;
    int t_fall = 0, t_rise = 0, gap = 0;
    bit gap_wait = 0;

    // ---------- converter model ----------
    bit no_busy = 0, no_sync = 0;
    logic [15:0] next_sample = 16'h0, conv_word = 16'hDEAD, out_word = 16'h0;
    logic rc_q = 1'b1;
    int bcnt = 0;
    bit armed = 0;
    int ridx = 0;

    always @(posedge clk) cyc = cyc + 1;
    always @(posedge clk) if (result_valid) valids <= valids + 1;
    always @(negedge rc_n) begin t_fall = cyc; convs++; end
    always @(posedge rc_n) begin t_rise = cyc; gap_wait = 1; end
    always @(posedge sclk) begin
        rises++;
        if (gap_wait && rc_n) begin gap = cyc - t_rise; gap_wait = 0; end
    end

    always @(posedge clk) begin
        rc_q <= rc_n;
        if (rc_q && !rc_n && !no_busy) begin
            bcnt      <= 1;
            out_word  <= conv_word;
            conv_word <= next_sample;
        end else if (bcnt != 0 && bcnt < 210) bcnt <= bcnt + 1;
        else bcnt <= 0;
        busy_n <= !(bcnt >= 4 && bcnt < 204);
    end

    always @(posedge sclk) begin
        if (!rc_n) begin
            armed <= 1; ridx <= 0;
        end else if (armed) begin
            ridx <= ridx + 1;
            if (ridx == 0) begin sync_in <= !no_sync; sdata_in <= 1'b0; end
            else if (ridx <= 16) begin sync_in <= 1'b0; sdata_in <= out_word[16 - ridx]; end
            else begin sync_in <= 1'b0; sdata_in <= 1'b0; armed <= 0; end
        end
    end

    // ---------- helpers ----------
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    logic [15:0] r_word;
    logic r_sync, r_stale, r_tmo;
    int r_rises, r_convs;

    task automatic do_read(input logic [15:0] sample, input bit poke_mid);
        int n0, c0, w;
        while (!busy_n || bcnt != 0) @(negedge clk);
        next_sample = sample;
        n0 = rises; c0 = convs;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (poke_mid) begin
            while (rises < n0 + 6) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            @(negedge clk) start = 1'b0;
        end
        w = 0;
        while (!result_valid && w < 2000) begin @(negedge clk); w++; end
        chk(result_valid == 1'b1, "R7", "strobe seen", result_valid, 1);
        r_word = result; r_sync = sync_err; r_stale = stale; r_tmo = timeout_err;
        @(negedge clk);
        chk(result_valid == 1'b0, "R7", "strobe one cycle", result_valid, 0);
        repeat (10) @(negedge clk);
        r_rises = rises - n0; r_convs = convs - c0;
    endtask

    // ---------- scenarios ----------
    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(rc_n == 1'b1 && sclk == 1'b0, "R1", "pins in reset", {rc_n, sclk}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rc_n == 1'b1, "R1", "rc_n idle", rc_n, 1);
        chk(sclk == 1'b0, "R1", "sclk idle", sclk, 0);
        chk(active == 1'b0 && result_valid == 1'b0, "R1", "active/valid idle",
            {active, result_valid}, 0);
    endtask

    task automatic t_first_read();
        do_read(16'h1234, 0);
        chk(r_stale == 1'b1, "R8", "first result stale", r_stale, 1);
        chk(t_rise - t_fall == RCW, "R2", "rc_n low width", t_rise - t_fall, RCW);
        chk(r_rises == 19, "R4", "pulses per read", r_rises, 19);
        chk(gap >= SETUP, "R3", "setup gap", gap, SETUP);
        chk(r_tmo == 1'b0, "R10", "no timeout", r_tmo, 0);
    endtask

    task automatic t_patterns();
        logic [15:0] prev;
        logic [15:0] pats [5];
        pats = '{16'hFFFF, 16'h0001, 16'h8000, 16'hA5C3, 16'h0000};
        prev = 16'h1234;
        foreach (pats[i]) begin
            do_read(pats[i], 0);
            chk(r_word == prev, "R6", "word msb first", r_word, prev);
            chk(r_stale == 1'b0, "R8", "not stale", r_stale, 0);
            chk(r_sync == 1'b0, "R5", "sync seen", r_sync, 0);
            prev = pats[i];
        end
    endtask

    task automatic t_no_sync();
        no_sync = 1;
        do_read(16'h3C3C, 0);
        no_sync = 0;
        chk(r_sync == 1'b1, "R5", "missing sync flagged", r_sync, 1);
        chk(r_word == 16'h0000, "R6", "word still read", r_word, 16'h0000);
    endtask

    task automatic t_start_mid_burst();
        int v0;
        v0 = valids;
        do_read(16'h5AA5, 1);
        chk(r_convs == 1, "R9", "one conversion only", r_convs, 1);
        chk(r_rises == 19, "R9", "no extra pulses", r_rises, 19);
        chk(valids - v0 == 1, "R9", "one strobe only", valids - v0, 1);
        chk(r_word == 16'h3C3C, "R6", "word after poke", r_word, 16'h3C3C);
    endtask

    task automatic t_timeout();
        no_busy = 1;
        do_read(16'h7777, 0);
        no_busy = 0;
        chk(r_tmo == 1'b1, "R10", "timeout flagged", r_tmo, 1);
        chk(r_word == 16'h0 && r_sync == 1'b0, "R10", "timeout result zero",
            {r_sync, r_word}, 0);
        chk(r_rises == 1, "R10", "only arming pulse", r_rises, 1);
        do_read(16'h0F0F, 0);
        chk(r_stale == 1'b1, "R8", "stale after timeout", r_stale, 1);
        chk(r_tmo == 1'b0, "R10", "timeout cleared", r_tmo, 0);
        do_read(16'hC001, 0);
        chk(r_word == 16'h0F0F, "R6", "word after recovery", r_word, 16'h0F0F);
        chk(r_stale == 1'b0, "R8", "fresh after recovery", r_stale, 0);
    endtask

    initial begin
        t_reset();
        t_first_read();
        t_patterns();
        t_no_sync();
        t_start_mid_burst();
        t_timeout();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule